// File: doc/BRIEF.md
# DRAM Compressed Parallel Test Mode Controller

This block is the device-side control logic of a small x4 dynamic memory that can enter a compressed test mode. It samples the active-low row strobe, column strobe and write strobe on a system clock, decides the type of each row cycle from the strobe levels seen in the sample where the row strobe falls, and runs a reduced-depth storage array behind that decoder. In normal mode a column strobe fall inside a row cycle performs a plain single-cell read or write, and further column strobe falls in the same row cycle give page accesses.

When the write strobe and column strobe are both low as the row strobe falls, the device enters test mode. There the two least significant column address bits are ignored: a write copies each data bit into the four cells of its group, and a read returns, per data bit, a high level when the four cells agree and a low level when they differ. A refresh cycle with the column strobe first but the write strobe high, or a row cycle with no column strobe fall at all, returns the device to normal mode. A test bench or test controller can watch the mode flag directly.

Top module: `dram_ptm_top`

## Requirements
- R1: After synchronous reset the mode flag is low (normal mode), the data-out enable is low and every array cell holds zero.
- R2: A row strobe fall sampled with column strobe low and write strobe low sets the mode flag from the next clock on; the same cycle issued while already in test mode leaves the flag high.
- R3: A row strobe fall sampled with column strobe low and write strobe high clears the mode flag, performs no array access and keeps the data-out enable low.
- R4: A row cycle that starts with column strobe high and ends (row strobe rises) without any column strobe fall clears the mode flag and leaves the array unchanged.
- R5: In normal mode, a column strobe fall with write strobe low inside a row cycle stores the 4-bit data input into the cell addressed by the latched row and the current column address.
- R6: In normal mode, a column strobe fall with write strobe high loads the addressed cell onto the data output from the next clock; the data-out enable is high only while read data is valid and output enable is low, and valid data is dropped when the row strobe rises or a write occurs.
- R7: In test mode a write stores the data input into all four cells whose column addresses differ only in column bits 1 and 0, whatever those two bits are.
- R8: In test mode a read drives data bit i high exactly when bit i of the four cells of the group is all ones or all zeros, and low otherwise; column bits 1 and 0 do not affect the result.
- R9: Several column strobe falls within one row strobe low period each perform their own access at the column address present at that fall.
- R10: A column strobe fall sampled in the same clock as the row strobe rise performs no access; if no earlier column strobe fall occurred in that row cycle, the cycle counts as a row-only refresh (R4).
- R11: The cycle type is fixed by the levels sampled at the row strobe fall, so a column strobe that falls in the same sample as the row strobe makes the cycle a refresh-type cycle, with no array access during that row strobe low period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (4) | Multiplexed row / column address |
| din | input | DQ_W (4) | Write data |
| dout | output | DQ_W (4) | Read data (cell contents or per-bit equality result) |
| dout_en | output | 1 | High when dout carries valid read data and is driven |
| test_mode | output | 1 | Mode flag: high in compressed test mode |

## Verification
The interesting coincidence is a column strobe fall landing in the same sample as a row strobe edge. The bench drives the column strobe low together with the row strobe fall, which must be classed as a refresh-type cycle with the write strobe deciding entry to test mode and no cell written, and also drives the column strobe fall together with the row strobe rise, which must perform no access and, with no prior column access, must drop test mode. Both are judged at the ports by the mode flag and by reading the targeted cells afterwards in normal mode against the bench's own array model.

// File: rtl/dram_ptm_pkg.sv
package dram_ptm_pkg;

    // Two ignored column bits give four cells per data bit in test mode.
    localparam int LANE_W = 2;
    localparam int LANES  = 1 << LANE_W;

    typedef enum logic [1:0] {
        CYC_IDLE    = 2'd0,
        CYC_ACCESS  = 2'd1,
        CYC_REFRESH = 2'd2
    } cyc_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic logic all_same(input logic [LANES-1:0] v);
        return (&v) | (~|v);
    endfunction

endpackage

// File: rtl/dram_ptm_strobe_dec.sv
module dram_ptm_strobe_dec
    import dram_ptm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc,
    output logic              cyc_end,
    output logic [ADDR_W-1:0] row_q,
    output logic              tm_q
);

    logic ras_q, cas_q, cas_seen_q;
    cyc_e cyc_q;
    logic ras_fall, ras_rise, cas_fall;

    always_comb begin
        ras_fall = ras_q & ~ras_n;
        ras_rise = ~ras_q & ras_n;
        cas_fall = cas_q & ~cas_n;
        acc      = ACC_NONE;
        if (cyc_q == CYC_ACCESS && !ras_n && cas_fall)
            acc = we_n ? ACC_READ : ACC_WRITE;
        cyc_end  = ras_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q      <= 1'b1;
            cas_q      <= 1'b1;
            cas_seen_q <= 1'b0;
            cyc_q      <= CYC_IDLE;
            row_q      <= '0;
            tm_q       <= 1'b0;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
            if (acc != ACC_NONE)
                cas_seen_q <= 1'b1;
            if (ras_fall) begin
                if (!cas_n) begin
                    cyc_q <= CYC_REFRESH;
                    tm_q  <= ~we_n;
                end else begin
                    cyc_q      <= CYC_ACCESS;
                    row_q      <= addr;
                    cas_seen_q <= 1'b0;
                end
            end else if (ras_rise) begin
                if (cyc_q == CYC_ACCESS && !cas_seen_q)
                    tm_q <= 1'b0;
                cyc_q <= CYC_IDLE;
            end
        end
    end

endmodule

// File: rtl/dram_ptm_array.sv
module dram_ptm_array
    import dram_ptm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_e              acc,
    input  logic              tm,
    input  logic [ADDR_W-1:0] row,
    input  logic [ADDR_W-1:0] col,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   rd_q
);

    localparam int IDX_W = 2 * ADDR_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [DQ_W-1:0]  mem_q [DEPTH];
    logic [DQ_W-1:0]  grp   [LANES];
    logic [DQ_W-1:0]  cmp;
    logic [DQ_W-1:0]  rd_next;
    logic [LANES-1:0] bits;
    logic [IDX_W-1:0] idx;

    assign idx = {row, col};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign grp[k] = mem_q[{row, col[ADDR_W-1:LANE_W], LANE_W'(k)}];
    end

    always_comb begin
        bits = '0;
        for (int i = 0; i < DQ_W; i++) begin
            for (int k = 0; k < LANES; k++)
                bits[k] = grp[k][i];
            cmp[i] = all_same(bits);
        end
        rd_next = tm ? cmp : mem_q[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < DEPTH; e++)
                mem_q[e] <= '0;
            rd_q <= '0;
        end else begin
            if (acc == ACC_WRITE) begin
                if (tm) begin
                    for (int k = 0; k < LANES; k++)
                        mem_q[{row, col[ADDR_W-1:LANE_W], LANE_W'(k)}] <= din;
                end else begin
                    mem_q[idx] <= din;
                end
            end
            if (acc == ACC_READ)
                rd_q <= rd_next;
        end
    end

endmodule

// File: rtl/dram_ptm_top.sv
module dram_ptm_top
    import dram_ptm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DQ_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dout,
    output logic              dout_en,
    output logic              test_mode
);

    acc_e              acc;
    logic              cyc_end;
    logic [ADDR_W-1:0] row_q;
    logic              tm_q;
    logic              valid_q;

    dram_ptm_strobe_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .addr    (addr),
        .acc     (acc),
        .cyc_end (cyc_end),
        .row_q   (row_q),
        .tm_q    (tm_q)
    );

    dram_ptm_array #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_arr (
        .clk  (clk),
        .rst  (rst),
        .acc  (acc),
        .tm   (tm_q),
        .row  (row_q),
        .col  (addr),
        .din  (din),
        .rd_q (dout)
    );

    always_ff @(posedge clk) begin
        if (rst)
            valid_q <= 1'b0;
        else if (acc == ACC_READ)
            valid_q <= 1'b1;
        else if (acc == ACC_WRITE || cyc_end)
            valid_q <= 1'b0;
    end

    assign dout_en   = valid_q & ~oe_n;
    assign test_mode = tm_q;

endmodule

// File: rtl/dram_ptm_chk.sv
module dram_ptm_chk (
    input logic clk,
    input logic rst,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic dout_en,
    input logic test_mode
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!test_mode && !dout_en));

    // R2
    mode_enter_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n && !we_n) |=> test_mode);

    // R3
    mode_leave_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n && we_n) |=> !test_mode);

    // R4
    mode_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(test_mode) |-> ($past(ras_n) != $past(ras_n, 2)));

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en);

    // R11
    refresh_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n) |=> !dout_en);

endmodule

bind dram_ptm_top dram_ptm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .dout_en   (dout_en),
    .test_mode (test_mode)
);

// File: tb/sim_dram_ptm_top.sv
module sim_dram_ptm_top;

    localparam int AW = 4;
    localparam int DW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, test_mode;

    int checks = 0;
    int errs = 0;
    bit mdl_tm = 1'b0;
    logic [DW-1:0] mdl [256];

    always #2.5 clk = ~clk;

    dram_ptm_top #(.ADDR_W(AW), .DQ_W(DW)) u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .test_mode(test_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] r, input logic [AW-1:0] c);
        logic [DW-1:0] res;
        if (!mdl_tm) return mdl[{r, c}];
        for (int i = 0; i < DW; i++) begin
            logic [3:0] b;
            for (int k = 0; k < 4; k++) b[k] = mdl[{r, c[AW-1:2], 2'(k)}][i];
            res[i] = (b == 4'h0) || (b == 4'hF);
        end
        return res;
    endfunction

    function automatic void mdl_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
        if (!mdl_tm) mdl[{r, c}] = d;
        else for (int k = 0; k < 4; k++) mdl[{r, c[AW-1:2], 2'(k)}] = d;
    endfunction

    task automatic row_open(input logic [AW-1:0] r);
        addr = r; ras_n = 1'b0; step();
    endtask

    task automatic row_close();
        ras_n = 1'b1; step(); step();
    endtask

    task automatic col_write(input logic [AW-1:0] r, input logic [AW-1:0] c, input logic [DW-1:0] d);
        addr = c; din = d; we_n = 1'b0; cas_n = 1'b0; step();
        cas_n = 1'b1; we_n = 1'b1; step();
        mdl_write(r, c, d);
    endtask

    task automatic col_read(input logic [AW-1:0] r, input logic [AW-1:0] c, input string req);
        logic [DW-1:0] e;
        e = exp_read(r, c);
        addr = c; we_n = 1'b1; cas_n = 1'b0; step();
        chk(dout_en === 1'b1, req, int'(dout_en), 1);
        chk(dout === e, req, int'(dout), int'(e));
        cas_n = 1'b1; step();
    endtask

    task automatic cbr_cycle(input bit wr);
        cas_n = 1'b0; we_n = ~wr; step();
        ras_n = 1'b0; step(); step();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(); step();
        mdl_tm = wr;
    endtask

    task automatic ras_only(input logic [AW-1:0] r);
        row_open(r); step(); row_close();
        mdl_tm = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errs++; checks++;
        $display("FAIL watchdog: run hung");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        for (int e = 0; e < 256; e++) mdl[e] = '0;
        step(); step(); step();
        rst = 1'b0; step();

        // R1: reset state and zeroed array
        chk(test_mode === 1'b0, "R1 mode", int'(test_mode), 0);
        chk(dout_en === 1'b0, "R1 dout_en", int'(dout_en), 0);
        row_open(4'h3); col_read(4'h3, 4'h9, "R1 cleared cell"); row_close();

        // R5, R6, R9: normal page writes and reads
        row_open(4'h5);
        col_write(4'h5, 4'h0, 4'hA);
        col_write(4'h5, 4'h1, 4'h3);
        col_write(4'h5, 4'h2, 4'hA);
        col_write(4'h5, 4'h3, 4'hA);
        col_read(4'h5, 4'h1, "R9 page read col1");
        col_read(4'h5, 4'h0, "R5 read back col0");
        oe_n = 1'b1; #1;
        chk(dout_en === 1'b0, "R6 oe high", int'(dout_en), 0);
        oe_n = 1'b0; #1;
        chk(dout_en === 1'b1, "R6 oe low", int'(dout_en), 1);
        row_close();
        chk(dout_en === 1'b0, "R6 dropped at row end", int'(dout_en), 0);

        // R2: enter test mode and stay on repeat
        cbr_cycle(1'b1);
        chk(test_mode === 1'b1, "R2 enter", int'(test_mode), 1);
        cbr_cycle(1'b1);
        chk(test_mode === 1'b1, "R2 repeat", int'(test_mode), 1);

        // R8: mixed group fails on bits that differ
        row_open(4'h5);
        col_read(4'h5, 4'h2, "R8 mixed group");
        col_read(4'h5, 4'h0, "R8 low bits ignored");
        // R7: test write fans out
        col_write(4'h5, 4'h6, 4'hC);
        col_read(4'h5, 4'h5, "R8 uniform group");
        row_close();

        // R3: plain refresh leaves test mode, no output
        cas_n = 1'b0; we_n = 1'b1; step();
        ras_n = 1'b0; step(); step();
        chk(dout_en === 1'b0, "R3 no output", int'(dout_en), 0);
        ras_n = 1'b1; cas_n = 1'b1; step(); step();
        mdl_tm = 1'b0;
        chk(test_mode === 1'b0, "R3 leave", int'(test_mode), 0);
        row_open(4'h5);
        for (int k = 4; k < 8; k++) col_read(4'h5, 4'(k), "R7 fan-out cell");
        row_close();

        // R4: row-only refresh leaves test mode, array intact
        cbr_cycle(1'b1);
        ras_only(4'h5);
        chk(test_mode === 1'b0, "R4 leave", int'(test_mode), 0);
        row_open(4'h5); col_read(4'h5, 4'h7, "R4 array intact"); row_close();

        // R10: column fall together with row rise
        cbr_cycle(1'b1);
        row_open(4'h2);
        ras_n = 1'b1; addr = 4'h8; din = 4'hF; we_n = 1'b0; cas_n = 1'b0; step();
        cas_n = 1'b1; we_n = 1'b1; step(); step();
        mdl_tm = 1'b0;
        chk(test_mode === 1'b0, "R10 counted as row-only", int'(test_mode), 0);
        row_open(4'h2);
        for (int k = 8; k < 12; k++) col_read(4'h2, 4'(k), "R10 no write");
        row_close();

        // R11: column and row strobe fall in the same sample
        addr = 4'h2; din = 4'h7; we_n = 1'b0; cas_n = 1'b0; ras_n = 1'b0; step(); step();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(); step();
        mdl_tm = 1'b1;
        chk(test_mode === 1'b1, "R11 refresh type", int'(test_mode), 1);
        cbr_cycle(1'b0);
        row_open(4'h2); col_read(4'h2, 4'h2, "R11 no access"); row_close();

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = $urandom % 10;
            if (sel == 0) begin
                cbr_cycle(1'b1);
                chk(test_mode === 1'b1, "R2 random", int'(test_mode), 1);
            end else if (sel == 1) begin
                cbr_cycle(1'b0);
                chk(test_mode === 1'b0, "R3 random", int'(test_mode), 0);
            end else if (sel == 2) begin
                ras_only(4'($urandom));
                chk(test_mode === 1'b0, "R4 random", int'(test_mode), 0);
            end else begin
                logic [AW-1:0] r;
                int n;
                r = 4'($urandom % 2);
                n = 1 + ($urandom % 3);
                row_open(r);
                for (int j = 0; j < n; j++) begin
                    if ($urandom % 2) col_write(r, 4'($urandom), 4'($urandom));
                    else col_read(r, 4'($urandom), mdl_tm ? "R8 random" : "R6 random");
                end
                row_close();
                chk(test_mode === mdl_tm, "R9 mode kept", int'(test_mode), int'(mdl_tm));
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule